// File: doc/BRIEF.md
# Track Protect and Status Word Unit

This unit sits between a host interface and the data path of a rotating store that has one head per track. It keeps the 16-bit command word that the host loads, which selects read or write and names a track and sector. It also builds the 16-bit status word that the host reads back. Two variants are chosen by a parameter. The disk variant has a 7-bit track field and a 7-bit sector field. The drum variant has a 10-bit track field and a 5-bit sector field.

Write permission comes from a protect switch and a count of protected low tracks. When the switch is on, every track below the count is read-only. A write to such a track is not refused: the data path simply sees write enable low, so the store keeps its old contents and no error bit appears. In the disk variant, each command-word load restarts a short read-inhibit timer. The status word shows read inhibit while that timer runs and the loaded command is a read.

Neighbouring blocks supply the live values: busy, sector flag and next sector. They also report sector coincidence, abort and parity error events, which this unit holds as sticky bits until a new transfer is started. A status access returns either the status word alone or the status word ORed into the supplied bus value.

Top module: `tgs_top`

## Requirements
- R1: A command-word load strobe stores the 16-bit input on the next clock edge. Bit 15 of the command word means write (1) or read (0). The disk variant takes the track from bits 13:7 and the sector from bits 6:0. The drum variant takes the track from bits 14:5 and the sector from bits 4:0.
- R2: The status word places the fields as follows: bit 15 sector flag, bits 14:8 next sector, bit 7 ready, bit 6 read inhibit, bit 5 sector coincidence, bit 3 abort, bit 2 write enabled, bit 1 parity error and bit 0 busy. Bit 4 reads 0.
- R3: Write enable, which is driven on the data-path line and also on status bit 2, is high when the protect switch is off, or when the commanded track number is greater than or equal to the protected-track count.
- R4: When the switch is on, the protected-track count is a power of two from 1 to 128. The drum variant also accepts 256, 512 and 768.
- R5: A write command to a protected track drives write enable low and raises no error: status bits 3 and 1 stay 0.
- R6: In the disk variant, each load starts or restarts a read-inhibit timer of INHIBIT_TICKS cycles (default 256). Status bit 6 is 1 for exactly INHIBIT_TICKS cycles after the load edge, provided the command is a read and a medium is attached.
- R7: In the drum variant, read inhibit always reads 0.
- R8: When no medium is attached, the sector flag, next sector, ready, read inhibit and busy bits read 0.
- R9: The sector coincidence, abort and parity error bits are set by one-cycle event inputs and then hold. A transfer-start pulse clears all three on the next edge. If a start and an event arrive in the same cycle, the start wins.
- R10: With merge selected, the status output is the bus input ORed with the status word. Otherwise the status output is the status word alone.
- R11: After reset the command word is 0, the timer is idle and the sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_load | input | 1 | Command-word load strobe |
| cw_in | input | 16 | Command word from host |
| xfer_start | input | 1 | New transfer started; clears sticky bits |
| prot_switch | input | 1 | Protect switch on |
| prot_tracks | input | 10 | Number of protected low tracks |
| medium_present | input | 1 | Medium attached |
| busy_in | input | 1 | Live busy from sequencer |
| sec_flag_in | input | 1 | Live sector flag |
| next_sec_in | input | 7 | Live next-sector count |
| coin_evt | input | 1 | Sector coincidence event |
| abort_evt | input | 1 | Abort event |
| parity_evt | input | 1 | Parity error event |
| merge_sel | input | 1 | 1: OR status into bus_in; 0: status alone |
| bus_in | input | 16 | Bus value for merge |
| cmd_word | output | 16 | Stored command word |
| write_en | output | 1 | Write enable to data path |
| status_out | output | 16 | Status word returned to host |

## Verification
The command word, the timer count and the sticky bits are registers, so each of them changes one edge after its strobe. Write enable and the status word are combinational from those registers and from the live inputs. The bench drives every input just after a falling edge and samples on the following falling edge. This puts a load's effect and a sticky set or clear one full cycle after the stimulus, and live inputs are visible in the same half cycle. For read inhibit, the bench counts exactly INHIBIT_TICKS falling edges after the load edge. It checks that the bit is still set on the last of them and clear on the next. Two instances, one of each variant, receive the same stimulus so that field decoding and the inhibit behaviour can be compared.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
   localparam int CW_W     = 16;
   localparam int TRK_W    = 10;
   localparam int NS_W     = 7;
   localparam int B_SECFLG = 15;
   localparam int B_NS_LO  = 8;
   localparam int B_READY  = 7;
   localparam int B_RINH   = 6;
   localparam int B_COIN   = 5;
   localparam int B_ABORT  = 3;
   localparam int B_WEN    = 2;
   localparam int B_PARITY = 1;
   localparam int B_BUSY   = 0;
   localparam int B_WRITE  = 15;

   function automatic logic count_legal(input logic drum, input logic [TRK_W-1:0] c);
      logic pow2;
      pow2 = (c != '0) && ((c & (c - TRK_W'(1))) == '0);
      return (pow2 && c <= TRK_W'(128)) ||
             (drum && (c == TRK_W'(256) || c == TRK_W'(512) || c == TRK_W'(768)));
   endfunction
endpackage

// File: rtl/tgs_cmd_reg.sv
module tgs_cmd_reg
   import tgs_pkg::*;
#(
   parameter bit DRUM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CW_W-1:0]  din,
   output logic [CW_W-1:0]  cw,
   output logic [TRK_W-1:0] track
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cw <= '0;
      else if (load) cw <= din;
   end

   generate
      if (DRUM) begin : g_drum
         assign track = cw[14:5];
      end else begin : g_disk
         assign track = TRK_W'(cw[13:7]);
      end
   endgenerate

   // R1: a load lands on the next edge
   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cw == $past(din));
   // R11/R1: without a load the word holds
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cw));
endmodule

// File: rtl/tgs_inhibit_timer.sv
module tgs_inhibit_timer #(
   parameter bit DRUM  = 1'b0,
   parameter int TICKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic running
);
   generate
      if (DRUM) begin : g_none
         assign running = 1'b0;
      end else begin : g_cnt
         localparam int CNT_W = $clog2(TICKS + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (restart) cnt <= CNT_W'(TICKS);
            else if (cnt != '0) cnt <= cnt - CNT_W'(1);
         end
         assign running = (cnt != '0);

         // R6: a load always leaves the timer running
         a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> running);
         // R6: the timer never starts on its own
         a_r6_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && !running) |=> !running);
      end
   endgenerate
endmodule

// File: rtl/tgs_sticky_flags.sv
module tgs_sticky_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic [2:0] set_evt,
   output logic [2:0] flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else if (clear) flags <= '0;
      else flags <= flags | set_evt;
   end

   // R9: start clears all three
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> flags == 3'b000);
   // R9: set bits hold until a start
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: rtl/tgs_top.sv
module tgs_top
   import tgs_pkg::*;
#(
   parameter bit DRUM          = 1'b0,
   parameter int INHIBIT_TICKS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cw_load,
   input  logic [15:0]      cw_in,
   input  logic             xfer_start,
   input  logic             prot_switch,
   input  logic [9:0]       prot_tracks,
   input  logic             medium_present,
   input  logic             busy_in,
   input  logic             sec_flag_in,
   input  logic [6:0]       next_sec_in,
   input  logic             coin_evt,
   input  logic             abort_evt,
   input  logic             parity_evt,
   input  logic             merge_sel,
   input  logic [15:0]      bus_in,
   output logic [15:0]      cmd_word,
   output logic             write_en,
   output logic [15:0]      status_out
);
   generate
      if (INHIBIT_TICKS < 1) begin : g_bad_ticks
         $error("INHIBIT_TICKS must be positive");
      end
      if (CW_W != 16 || NS_W != 7 || TRK_W != 10) begin : g_bad_layout
         $error("status layout needs a 16-bit word");
      end
   endgenerate

   logic [TRK_W-1:0] track;
   logic             inh_run;
   logic [2:0]       sticky;   // {coin, abort, parity}
   logic [CW_W-1:0]  stat;

   tgs_cmd_reg #(.DRUM(DRUM)) u_cmd (
      .clk(clk), .rst_n(rst_n), .load(cw_load), .din(cw_in),
      .cw(cmd_word), .track(track));

   tgs_inhibit_timer #(.DRUM(DRUM), .TICKS(INHIBIT_TICKS)) u_inh (
      .clk(clk), .rst_n(rst_n), .restart(cw_load), .running(inh_run));

   tgs_sticky_flags u_sticky (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start),
      .set_evt({coin_evt, abort_evt, parity_evt}), .flags(sticky));

   assign write_en = !prot_switch || (track >= prot_tracks);

   always_comb begin
      stat                        = '0;
      stat[B_WEN]                 = write_en;
      stat[B_COIN]                = sticky[2];
      stat[B_ABORT]               = sticky[1];
      stat[B_PARITY]              = sticky[0];
      if (medium_present) begin
         stat[B_SECFLG]           = sec_flag_in;
         stat[B_NS_LO +: NS_W]    = next_sec_in;
         stat[B_READY]            = 1'b1;
         stat[B_BUSY]             = busy_in;
         stat[B_RINH]             = inh_run && !cmd_word[B_WRITE];
      end
   end

   assign status_out = (merge_sel ? bus_in : '0) | stat;

   // R4: protected-track count is a legal value whenever it matters
   a_r4_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      prot_switch |-> count_legal(DRUM, prot_tracks));
   // R8: no live bits without a medium
   a_r8_unattached: assert property (@(posedge clk) disable iff (!rst_n)
      (!medium_present && !merge_sel) |->
         (status_out[15:6] == '0 && status_out[B_BUSY] == 1'b0));
   // R5: a blocked write never shows abort or parity on its own account
   a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!write_en && !abort_evt && !parity_evt && !merge_sel &&
       $past(status_out[B_ABORT]) == 1'b0 && $past(status_out[B_PARITY]) == 1'b0)
         |=> (status_out[B_ABORT] == 1'b0 && status_out[B_PARITY] == 1'b0));
   // R2: bit 4 always reads 0 without merge
   a_r2_bit4: assert property (@(posedge clk) disable iff (!rst_n)
      !merge_sel |-> status_out[4] == 1'b0);
endmodule

// File: tb/tgs_top_tb_top.sv
module tgs_top_tb_top;
   localparam int TICKS = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cw_load = 0, xfer_start = 0, prot_switch = 0, medium_present = 0;
   logic busy_in = 0, sec_flag_in = 0, coin_evt = 0, abort_evt = 0, parity_evt = 0;
   logic merge_sel = 0;
   logic [15:0] cw_in = '0, bus_in = '0;
   logic [9:0]  prot_d = 10'd1, prot_r = 10'd1;
   logic [6:0]  next_sec_in = '0;
   logic [15:0] cmd_d, cmd_r, st_d, st_r;
   logic        we_d, we_r;

   int checks = 0;
   int errors = 0;
   bit timed_out = 0;

   always #5 clk = ~clk;

   tgs_top #(.DRUM(1'b0), .INHIBIT_TICKS(TICKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cw_load(cw_load), .cw_in(cw_in),
      .xfer_start(xfer_start), .prot_switch(prot_switch), .prot_tracks(prot_d),
      .medium_present(medium_present), .busy_in(busy_in), .sec_flag_in(sec_flag_in),
      .next_sec_in(next_sec_in), .coin_evt(coin_evt), .abort_evt(abort_evt),
      .parity_evt(parity_evt), .merge_sel(merge_sel), .bus_in(bus_in),
      .cmd_word(cmd_d), .write_en(we_d), .status_out(st_d));

   tgs_top #(.DRUM(1'b1), .INHIBIT_TICKS(TICKS)) dut_drum_i (
      .clk(clk), .rst_n(rst_n), .cw_load(cw_load), .cw_in(cw_in),
      .xfer_start(xfer_start), .prot_switch(prot_switch), .prot_tracks(prot_r),
      .medium_present(medium_present), .busy_in(busy_in), .sec_flag_in(sec_flag_in),
      .next_sec_in(next_sec_in), .coin_evt(coin_evt), .abort_evt(abort_evt),
      .parity_evt(parity_evt), .merge_sel(merge_sel), .bus_in(bus_in),
      .cmd_word(cmd_r), .write_en(we_r), .status_out(st_r));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_cw(input logic [15:0] v);
      cw_in = v; cw_load = 1'b1;
      tick(1);
      cw_load = 1'b0;
   endtask

   // expected track per R1
   function automatic logic [9:0] trk(input bit drum, input logic [15:0] cw);
      return drum ? cw[14:5] : {3'b000, cw[13:7]};
   endfunction

   function automatic logic exp_we(input bit drum, input logic [15:0] cw,
                                   input logic sw, input logic [9:0] cnt);
      return !sw || (trk(drum, cw) >= cnt);
   endfunction

   task automatic t_reset;
      chk("R11 disk cmd", cmd_d, 16'h0000);
      chk("R11 drum cmd", cmd_r, 16'h0000);
      chk("R11 disk status", st_d, 16'h0004);
      chk("R11 drum status", st_r, 16'h0004);
   endtask

   task automatic t_load;
      load_cw(16'hA5C3);
      chk("R1 disk cmd", cmd_d, 16'hA5C3);
      chk("R1 drum cmd", cmd_r, 16'hA5C3);
      cw_in = 16'h1234;
      tick(1);
      chk("R1 hold without strobe", cmd_d, 16'hA5C3);
   endtask

   task automatic t_layout;
      load_cw(16'h8000);             // write command, no inhibit shown
      medium_present = 1; sec_flag_in = 1; next_sec_in = 7'h55; busy_in = 1;
      tick(1);
      // 15:1, 14:8=55, 7:1, 6:0, 5:0, 4:0, 3:0, 2:1, 1:0, 0:1
      chk("R2 disk layout", st_d, 16'hD585);
      sec_flag_in = 0; busy_in = 0; next_sec_in = 7'h2A;
      tick(1);
      chk("R2 drum layout", st_r, 16'h2A84);
      medium_present = 0; next_sec_in = '0;
   endtask

   task automatic t_protect;
      logic [15:0] v;
      prot_switch = 1; prot_d = 10'd8; prot_r = 10'd8;
      v = 16'(7 << 7);
      load_cw(v);
      chk("R3 disk track 7 below 8", {15'd0, we_d}, {15'd0, exp_we(0, v, 1, 10'd8)});
      chk("R3 drum same word", {15'd0, we_r}, {15'd0, exp_we(1, v, 1, 10'd8)});
      chk("R3 disk status bit2", {15'd0, st_d[2]}, {15'd0, exp_we(0, v, 1, 10'd8)});
      v = 16'(8 << 7);
      load_cw(v);
      chk("R3 disk track 8 at count", {15'd0, we_d}, 16'd1);
      v = 16'(3 << 5);
      load_cw(v);
      chk("R3 drum track 3 below 8", {15'd0, we_r}, {15'd0, exp_we(1, v, 1, 10'd8)});
      prot_switch = 0;
      tick(1);
      chk("R3 switch off enables", {14'd0, we_d, we_r}, 16'd3);
   endtask

   task automatic t_drum_big;
      logic [15:0] v;
      prot_switch = 1; prot_d = 10'd128; prot_r = 10'd768;
      v = 16'(767 << 5);
      load_cw(v);
      chk("R4 drum track 767 with 768", {15'd0, we_r}, 16'd0);
      chk("R4 disk track under 128", {15'd0, we_d}, {15'd0, exp_we(0, v, 1, 10'd128)});
      v = 16'(768 << 5);
      load_cw(v);
      chk("R4 drum track 768 with 768", {15'd0, we_r}, 16'd1);
      prot_switch = 0; prot_d = 10'd1; prot_r = 10'd1;
   endtask

   task automatic t_blocked_write;
      prot_switch = 1; prot_d = 10'd16;
      load_cw(16'h8000 | 16'(2 << 7));   // write to disk track 2
      tick(3);
      chk("R5 write enable low", {15'd0, we_d}, 16'd0);
      chk("R5 no error bits", {12'd0, st_d[3], st_d[1], st_d[2], 1'b0}, 16'd0);
      prot_switch = 0; prot_d = 10'd1;
   endtask

   task automatic t_inhibit;
      medium_present = 1;
      load_cw(16'h0001);
      chk("R6 inhibit after load", {15'd0, st_d[6]}, 16'd1);
      chk("R7 drum never inhibits", {15'd0, st_r[6]}, 16'd0);
      tick(TICKS - 1);
      chk("R6 inhibit last cycle", {15'd0, st_d[6]}, 16'd1);
      tick(1);
      chk("R6 inhibit expired", {15'd0, st_d[6]}, 16'd0);
      load_cw(16'h0002);
      tick(100);
      load_cw(16'h0003);              // restart mid-run
      tick(TICKS - 1);
      chk("R6 restart extends", {15'd0, st_d[6]}, 16'd1);
      tick(1);
      chk("R6 restart expired", {15'd0, st_d[6]}, 16'd0);
      load_cw(16'h8003);              // write: timer runs, bit hidden
      chk("R6 write hides inhibit", {15'd0, st_d[6]}, 16'd0);
      load_cw(16'h0003);
      medium_present = 0;
      tick(1);
      chk("R8 inhibit hidden unattached", {15'd0, st_d[6]}, 16'd0);
      tick(TICKS);
   endtask

   task automatic t_unattached;
      medium_present = 0; sec_flag_in = 1; busy_in = 1; next_sec_in = 7'h7F;
      tick(1);
      chk("R8 disk live bits zero", st_d & 16'hFFC1, 16'h0000);
      chk("R8 drum live bits zero", st_r & 16'hFFC1, 16'h0000);
      sec_flag_in = 0; busy_in = 0; next_sec_in = '0;
   endtask

   task automatic t_sticky;
      coin_evt = 1; tick(1); coin_evt = 0;
      abort_evt = 1; tick(1); abort_evt = 0;
      parity_evt = 1; tick(1); parity_evt = 0;
      tick(5);
      chk("R9 sticky held", st_d & 16'h002A, 16'h002A);
      xfer_start = 1; abort_evt = 1; tick(1); xfer_start = 0; abort_evt = 0;
      chk("R9 start clears, wins over event", st_d & 16'h002A, 16'h0000);
      parity_evt = 1; tick(1); parity_evt = 0;
      chk("R9 parity alone", st_r & 16'h002A, 16'h0002);
      xfer_start = 1; tick(1); xfer_start = 0;
   endtask

   task automatic t_merge;
      bus_in = 16'h0150; merge_sel = 1;
      tick(1);
      chk("R10 merge ORs bus", st_d, 16'h0154);
      merge_sel = 0;
      tick(1);
      chk("R10 load ignores bus", st_d, 16'h0004);
      bus_in = '0;
   endtask

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_load();
      t_layout();
      t_protect();
      t_drum_big();
      t_blocked_write();
      t_inhibit();
      t_unattached();
      t_sticky();
      t_merge();
      if (!timed_out) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      timed_out = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule